// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a 32-bit free-running tick counter with a programmed period and a level interrupt. Software reaches it through two registers. The control register carries a two-bit run mode, an interrupt enable, a sticky pending flag and a 28-bit period. The count register holds the running count, and software can both write it and read its live value.

The counter advances by one on every cycle in which the tick enable is high and the timer is running. When the low 28 bits of the count equal the period, the pending flag is set. The mode then decides what follows: the count reloads to zero, the count halts, or the count keeps running and wraps. The interrupt line is high while the pending flag and the enable are both set.

Counting starts and stops only when a control write changes the mode. A control write that keeps the same mode leaves the run state alone. This means a one-shot timer that has already expired stays halted when software writes the one-shot mode again.

A two-state machine tracks whether the counter runs. It has two states:
- `ST_HALT`, the counter holds.
- `ST_COUNT`, the counter advances on ticks.

It has three transitions:
- START goes from `ST_HALT` to `ST_COUNT` when a write changes the mode to a non-zero value.
- STOP goes from `ST_COUNT` to `ST_HALT` when a write changes the mode to 00.
- EXPIRE goes from `ST_COUNT` to `ST_HALT` on a period match in one-shot mode, when there is no mode change in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, both registers read 0, `irq` is low and the counter is halted.
- R2: With `rd_sel`=0, `rd_data` returns the control register:
  - bits 31:30 are the mode (00 off, 01 auto-reload, 10 one-shot, 11 free-running);
  - bit 29 is the interrupt enable;
  - bit 28 is the pending flag;
  - bits 27:0 are the period.
  With `rd_sel`=1, `rd_data` returns the live count. On writes, `wr_sel`=0 selects the control register and `wr_sel`=1 selects the count register.
- R3: While running, the count rises by one on each clock edge where `tick_en` is 1. It holds when `tick_en` is 0 or when the counter is halted.
- R4: A control write that changes the mode to 00 halts the counter (STOP). A control write that changes the mode to any non-zero value runs it (START).
- R5: A control write whose mode equals the current mode leaves the run state unchanged.
- R6: On a counted tick where count bits 27:0 equal the period, the pending flag becomes 1.
- R7: In auto-reload mode, a match reloads the count to 0.
- R8: In one-shot mode, a match holds the count and halts the counter (EXPIRE).
- R9: In free-running mode, a match does not disturb counting, and the count wraps from 0xFFFFFFFF to 0.
- R10: A control write with bit 28 = 1 keeps the current pending flag and never sets it by itself. A control write with bit 28 = 0 clears the flag, and this clear wins over a match in the same cycle.
- R11: `irq` is high exactly when the pending flag and the interrupt enable are both 1. A match with the enable at 0 still sets the pending flag.
- R12: A count write is visible on the next cycle and wins over an increment or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 count |
| rd_data | output | 32 | Read data, combinational from the selected register |
| tick_en | input | 1 | Count enable for this cycle |
| irq | output | 1 | Level timer interrupt |

## Verification
Each mode is driven through a match and observed in the count afterwards:
- in auto-reload mode, a repeated zero count shows the reload;
- in one-shot mode, a frozen count shows the halt;
- in free-running mode, the count passing the period and wrapping past 0xFFFFFFFF shows that it keeps running.

Control writes are issued in pairs, one that changes the mode and one that repeats it. Comparing the two separates a run-state change from a no-op, and this is most visible on an expired one-shot timer. The pending flag is written both as 1 and as 0, with the interrupt enabled and masked, to tell keeping the flag apart from clearing it and masking apart from clearing. Same-cycle collisions are tested directly: a count write against a tick, and a pending clear against a match.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int DATA_W   = 32;
    localparam int MODE_W   = 2;
    localparam int PER_W    = DATA_W - MODE_W - 2;
    localparam int PEND_BIT = PER_W;
    localparam int IE_BIT   = PER_W + 1;
    localparam int MODE_LO  = PER_W + 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_ONCE = 2'b10,
        MODE_FREE = 2'b11
    } tt_mode_e;

    typedef struct packed {
        tt_mode_e           mode;
        logic               ie;
        logic               pend;
        logic [PER_W-1:0]   period;
    } tt_ctl_t;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tt_run_e;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_CNT = 1'b1;
endpackage

// File: rtl/tt_ctl_reg.sv
module tt_ctl_reg
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hit,
    output tt_ctl_t           ctl_q,
    output logic              mode_chg
);
    tt_ctl_t wr_v;

    assign wr_v     = tt_ctl_t'(wr_data);
    assign mode_chg = wr && (wr_v.mode != ctl_q.mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q.mode   <= wr_v.mode;
            ctl_q.ie     <= wr_v.ie;
            ctl_q.period <= wr_v.period;
            // writing 1 keeps the flag (a match may still set it); 0 clears, winning over a match
            ctl_q.pend   <= wr_v.pend ? (ctl_q.pend | hit) : 1'b0;
        end else if (hit) begin
            ctl_q.pend   <= 1'b1;
        end
    end
endmodule

// File: rtl/tt_run_fsm.sv
module tt_run_fsm
    import tt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_chg,
    input  tt_mode_e new_mode,
    input  logic     once_done,
    output logic     running
);
    tt_run_e state_q;
    tt_run_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (mode_chg && (new_mode != MODE_OFF)) begin
                    state_d = ST_COUNT;             // START
                end
            end
            ST_COUNT: begin
                if (mode_chg && (new_mode == MODE_OFF)) begin
                    state_d = ST_HALT;              // STOP
                end else if (!mode_chg && once_done) begin
                    state_d = ST_HALT;              // EXPIRE
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        running = (state_q == ST_COUNT);
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          tick_en,
    input  logic          sw_wr,
    input  logic [W-1:0]  sw_data,
    input  logic [PW-1:0] period,
    input  tt_mode_e      mode,
    output logic [W-1:0]  cnt_q,
    output logic          hit,
    output logic          once_done
);
    logic step;

    assign step      = running && tick_en;
    assign hit       = step && (cnt_q[PW-1:0] == period);
    assign once_done = hit && (mode == MODE_ONCE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sw_wr) begin
            cnt_q <= sw_data;
        end else if (step) begin
            if (hit && (mode == MODE_AUTO)) begin
                cnt_q <= '0;
            end else if (!once_done) begin
                cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_en,
    output logic              irq
);
    tt_ctl_t           ctl_q;
    logic [DATA_W-1:0] cnt_q;
    logic              ctl_wr;
    logic              cnt_wr;
    logic              mode_chg;
    logic              hit;
    logic              once_done;
    logic              running;

    assign ctl_wr = wr_en && (wr_sel == SEL_CTL);
    assign cnt_wr = wr_en && (wr_sel == SEL_CNT);

    tt_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wr_data  (wr_data),
        .hit      (hit),
        .ctl_q    (ctl_q),
        .mode_chg (mode_chg)
    );

    tt_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_chg  (mode_chg),
        .new_mode  (tt_mode_e'(wr_data[DATA_W-1:MODE_LO])),
        .once_done (once_done),
        .running   (running)
    );

    tt_counter #(.W(DATA_W), .PW(PER_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .tick_en   (tick_en),
        .sw_wr     (cnt_wr),
        .sw_data   (wr_data),
        .period    (ctl_q.period),
        .mode      (ctl_q.mode),
        .cnt_q     (cnt_q),
        .hit       (hit),
        .once_done (once_done)
    );

    assign rd_data = (rd_sel == SEL_CNT) ? cnt_q : DATA_W'(ctl_q);
    assign irq     = ctl_q.pend && ctl_q.ie;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick_en,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] ctl,
    input logic              running
);
    logic ctl_w;
    logic cnt_w;
    logic match;

    assign ctl_w = wr_en && (wr_sel == SEL_CTL);
    assign cnt_w = wr_en && (wr_sel == SEL_CNT);
    assign match = running && tick_en && (cnt[PER_W-1:0] == ctl[PER_W-1:0]);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl[IE_BIT]); // R11

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_w) |=> $stable(cnt)); // R3

    AST_CNT_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w |=> (cnt == $past(wr_data))); // R12

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !wr_data[PEND_BIT]) |=> !ctl[PEND_BIT]); // R10

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[PEND_BIT] && !(ctl_w && !wr_data[PEND_BIT])) |=> ctl[PEND_BIT]); // R10

    AST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && (wr_data[DATA_W-1:MODE_LO] == MODE_OFF)) |=> !running); // R4

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && (wr_data[DATA_W-1:MODE_LO] != MODE_OFF)
         && (wr_data[DATA_W-1:MODE_LO] != ctl[DATA_W-1:MODE_LO])) |=> running); // R4

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cnt_w && (ctl[DATA_W-1:MODE_LO] == MODE_AUTO)) |=> (cnt == '0)); // R7

    AST_MATCH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !ctl_w) |=> ctl[PEND_BIT]); // R6
endmodule

bind tick_timer tick_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .tick_en (tick_en),
    .irq     (irq),
    .cnt     (cnt_q),
    .ctl     (DATA_W'(ctl_q)),
    .running (running)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;
    // {kind[74:73], data[72:41], ticks[40:33], exp_cnt[32:1], exp_irq[0]}; kind 0 none, 1 ctl, 2 cnt
    localparam logic [74:0] VEC [NV] = '{
        {2'd2, 32'h0000_0000, 8'd5, 32'h0000_0000, 1'b0}, // R3 off: no count
        {2'd1, 32'hE000_000A, 8'd5, 32'h0000_0005, 1'b0}, // R4 start free-running
        {2'd0, 32'h0,         8'd5, 32'h0000_000A, 1'b0}, // R3
        {2'd0, 32'h0,         8'd1, 32'h0000_000B, 1'b1}, // R9 match, keeps counting
        {2'd1, 32'hF000_000A, 8'd2, 32'h0000_000D, 1'b1}, // R5 same mode, pend kept
        {2'd1, 32'hE000_000A, 8'd0, 32'h0000_000D, 1'b0}, // R10 clear
        {2'd2, 32'h0000_0000, 8'd0, 32'h0000_0000, 1'b0}, // R12
        {2'd1, 32'h6000_0003, 8'd3, 32'h0000_0003, 1'b0}, // R7 auto
        {2'd0, 32'h0,         8'd1, 32'h0000_0000, 1'b1}, // R7 reload
        {2'd0, 32'h0,         8'd4, 32'h0000_0000, 1'b1}, // R7 second lap
        {2'd1, 32'h6000_0003, 8'd2, 32'h0000_0002, 1'b0}, // R10 clear
        {2'd1, 32'hA000_0002, 8'd1, 32'h0000_0002, 1'b1}, // R8 one-shot hits
        {2'd0, 32'h0,         8'd3, 32'h0000_0002, 1'b1}, // R8 halted
        {2'd1, 32'hB000_0002, 8'd3, 32'h0000_0002, 1'b1}, // R5 no restart
        {2'd1, 32'h2000_0002, 8'd3, 32'h0000_0002, 1'b0}, // R4 stop
        {2'd2, 32'h1234_5670, 8'd2, 32'h1234_5670, 1'b0}, // R12 write while off
        {2'd1, 32'hC234_5675, 8'd3, 32'h1234_5673, 1'b0}, // R4 start, ie off
        {2'd0, 32'h0,         8'd3, 32'h1234_5676, 1'b0}, // R11 masked match
        {2'd1, 32'hF234_5675, 8'd0, 32'h1234_5676, 1'b1}  // R11 unmask
    };
    localparam int VREQ [NV] = '{3, 4, 3, 9, 5, 10, 12, 7, 7, 7, 10, 8, 8, 5, 4, 12, 4, 11, 11};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b1;
    logic [31:0] rd_data;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .tick_en (tick_en),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_sel = 1'b0; #1;
        check("R1 ctl", rd_data, 32'h0);
        rd_sel = 1'b1; #1;
        check("R1 cnt", rd_data, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][74:73] == 2'd1) write_reg(1'b0, VEC[i][72:41]);
            else if (VEC[i][74:73] == 2'd2) write_reg(1'b1, VEC[i][72:41]);
            else @(negedge clk);
            run_ticks(int'(VEC[i][40:33]));
            rd_sel = 1'b1; #1;
            check($sformatf("R%0d vec %0d cnt", VREQ[i], i), rd_data, VEC[i][32:1]);
            check($sformatf("R%0d vec %0d irq", VREQ[i], i), {31'b0, irq}, {31'b0, VEC[i][0]});
        end

        // R2 control read-back layout
        rd_sel = 1'b0; #1;
        check("R2 ctl read", rd_data, 32'hF234_5675);
        rd_sel = 1'b1;

        // R12 count write collides with a tick while running
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_0100; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0; #1;
        check("R12 collision", rd_data, 32'h0000_0100);
        run_ticks(2); #1;
        check("R3 after collision", rd_data, 32'h0000_0102);

        // R9 wrap in free-running mode
        write_reg(1'b1, 32'hFFFF_FFFE);
        run_ticks(3); #1;
        check("R9 wrap", rd_data, 32'h0000_0001);

        // R10 pending clear wins over a same-cycle match (pend currently 1)
        write_reg(1'b1, 32'h0234_5675);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hE234_5675; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0; #1;
        check("R10 clear vs match irq", {31'b0, irq}, 32'h0);
        check("R6 counted through match", rd_data, 32'h0234_5676);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #1;
        check("R1 cnt after reset", rd_data, 32'h0);
        run_ticks(2); #1;
        check("R1 halted after reset", rd_data, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule